// File: doc/BRIEF.md
# Host-Side Instrument Bus Transaction Sequencer

This block is the controller end of a simple parallel instrument bus. A host with an I/O-mapped register port writes a data byte and then a command word. The block then runs one timed bus transaction on its own. The bus carries a 4-bit command code, a ready strobe, a low/high byte select, an acknowledge line and an 8-bit bidirectional data bus. The data bus passes through an external transceiver, and the block drives that transceiver's enable and direction. Up to 16 instruments sit on the bus, each with a 4-bit address. A register write to an instrument is three transactions in a row: select (code 15) with the instrument address, load register address (code 5), then write (code 1) with the data byte.

Each transaction has three phases. A setup phase places the code, the select bit and any outbound data on the bus with the transceiver enabled. A ready (or acknowledge) strobe follows. A one-cycle hold phase comes last, and inbound data is sampled in that cycle. The transceiver is enabled only during these phases. The direction flips only while the transceiver is off, and at least one dead cycle separates the flip from the next enable. The shared service-request line reaches the host interrupt only when software has set an enable bit. An acknowledge transaction reads the requester's address from the low data nibble.

Top module: `ibus_host_seq`

## Requirements
- R1: A host access takes effect only when addr_i[9:2] equals BASE_ADDR and aen_i is low. Otherwise writes change nothing and rdata_o reads 0.
- R2: bus_oe_o is high only during the setup, strobe and hold phases of a transaction. It is low after reset and between transactions.
- R3: bus_dir_o (1 = outbound, 0 = inbound, reset 1) changes only on a cycle where bus_oe_o is low and was low on the cycle before. When the direction must change, exactly one cycle with bus_oe_o low passes between the command write and the enable. When it need not change, that gap is zero cycles.
- R4: The ready strobe rises only after at least one setup cycle in which bus_oe_o is high and cmd_o and bus_d_o already hold their final values.
- R5: The timing register at offset 3 holds the setup count in bits [3:0] and the strobe count in bits [7:4], and reads back as written. Its reset value is 0x11. A setup count of s gives s+1 setup cycles, and a strobe count of w gives w+1 strobe cycles.
- R6: Command codes 2, 3 and 4 are reads. They, and acknowledge transactions, run with bus_dir_o = 0 from setup onward.
- R7: On inbound transactions, bus_d_i is sampled in the single hold cycle that follows the last strobe cycle. The byte from a read command is readable at offset 0.
- R8: A write to offset 1 starts a transaction. Offset 1 bit 0 reads 1 from the next cycle until the transaction ends. While that bit is 1, host writes to offsets 0, 1 and 3 are ignored.
- R9: irq_o is high exactly when sr_i is high and the enable bit, offset 2 bit 0, is set.
- R10: A command write with bit 5 set is an acknowledge transaction. It drives ack_o during the strobe phase with rdy_o held low. The hold-cycle low nibble of bus_d_i is captured and reads back at offset 2 bits [7:4].
- R11: During the strobe of an outbound transaction, cmd_o carries command bits [3:0] and bus_d_o carries the byte last written to offset 0.
- R12: hl_o follows command bit 4 during the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Host I/O address |
| aen_i | input | 1 | Host address-enable; high blocks decoding |
| wr_i | input | 1 | Host write strobe, one cycle |
| rd_i | input | 1 | Host read strobe |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| sr_i | input | 1 | Shared service-request line, active high |
| irq_o | output | 1 | Gated host interrupt |
| cmd_o | output | 4 | Bus command code |
| rdy_o | output | 1 | Bus ready strobe |
| hl_o | output | 1 | Low/high byte select |
| ack_o | output | 1 | Service-request acknowledge strobe |
| bus_oe_o | output | 1 | Transceiver enable |
| bus_dir_o | output | 1 | Transceiver direction, 1 = outbound |
| bus_d_o | output | 8 | Outbound data byte |
| bus_d_i | input | 8 | Inbound data byte |

## Verification
The bench uses the default parameters: BASE_ADDR 0xC4, which decodes host addresses 0x310 to 0x313, and 4-bit phase counters. Programming the counters to 0/0, 1/1 and 5/3 covers the shortest transaction, the reset timing and a stretched one. Phase lengths are measured cycle by cycle. Mixing read, write and acknowledge commands makes the direction flip in both ways and also stay put, so the dead-cycle rule is seen in both cases. A decoy byte on bus_d_i during the strobe, replaced in the hold cycle, pins down the exact sampling cycle.

// File: rtl/ibus_pkg.sv
package ibus_pkg;
  localparam logic [3:0] CODE_RESET  = 4'd0;
  localparam logic [3:0] CODE_WRITE  = 4'd1;
  localparam logic [3:0] CODE_RD_REG = 4'd2;
  localparam logic [3:0] CODE_RD_MEM = 4'd3;
  localparam logic [3:0] CODE_RD_ST  = 4'd4;
  localparam logic [3:0] CODE_LD_RA  = 4'd5;
  localparam logic [3:0] CODE_SELECT = 4'd15;

  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_CMD  = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_TIM  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_SETUP, ST_STROBE, ST_HOLD
  } seq_state_e;

  function automatic logic code_inbound(input logic [3:0] code);
    return (code == CODE_RD_REG) || (code == CODE_RD_MEM) || (code == CODE_RD_ST);
  endfunction
endpackage

// File: rtl/ibus_host_regs.sv
module ibus_host_regs
  import ibus_pkg::*;
#(
  parameter int AW = 10,
  parameter logic [AW-3:0] BASE_ADDR = 8'hC4,
  parameter int CNT_W = 4,
  parameter logic [CNT_W-1:0] DEF_SETUP = 1,
  parameter logic [CNT_W-1:0] DEF_STROBE = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             aen_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             sr_i,
  output logic             irq_o,
  input  logic             busy_i,
  input  logic             cap_valid_i,
  input  logic             cap_ack_i,
  input  logic [7:0]       cap_data_i,
  output logic             start_o,
  output logic [3:0]       start_code_o,
  output logic             start_hl_o,
  output logic             start_ack_o,
  output logic [7:0]       tx_data_o,
  output logic [CNT_W-1:0] setup_o,
  output logic [CNT_W-1:0] strobe_o
);
  logic             cs;
  logic [1:0]       ofs;
  logic             wr_ok;
  logic [7:0]       tx_q, rx_q;
  logic [3:0]       req_q;
  logic             irq_en_q;
  logic [CNT_W-1:0] setup_q, strobe_q;
  logic [7:0]       tim_rd;

  assign cs    = (addr_i[AW-1:2] == BASE_ADDR) && !aen_i;
  assign ofs   = addr_i[1:0];
  assign wr_ok = cs && wr_i;

  // writes that feed a running transaction are frozen while busy
  assign start_o      = wr_ok && (ofs == OFS_CMD) && !busy_i;
  assign start_code_o = wdata_i[3:0];
  assign start_hl_o   = wdata_i[4];
  assign start_ack_o  = wdata_i[5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q     <= '0;
      rx_q     <= '0;
      req_q    <= '0;
      irq_en_q <= 1'b0;
      setup_q  <= DEF_SETUP;
      strobe_q <= DEF_STROBE;
    end else begin
      if (wr_ok && !busy_i && ofs == OFS_DATA) tx_q <= wdata_i;
      if (wr_ok && !busy_i && ofs == OFS_TIM) begin
        setup_q  <= wdata_i[CNT_W-1:0];
        strobe_q <= wdata_i[4 +: CNT_W];
      end
      if (wr_ok && ofs == OFS_CTRL) irq_en_q <= wdata_i[0];
      if (cap_valid_i) begin
        if (cap_ack_i) req_q <= cap_data_i[3:0];
        else           rx_q  <= cap_data_i;
      end
    end
  end

  always_comb begin
    tim_rd = '0;
    tim_rd[CNT_W-1:0] = setup_q;
    tim_rd[4 +: CNT_W] = strobe_q;
  end

  always_comb begin
    rdata_o = '0;
    if (cs && rd_i) begin
      unique case (ofs)
        OFS_DATA: rdata_o = rx_q;
        OFS_CMD:  rdata_o = {7'd0, busy_i};
        OFS_CTRL: rdata_o = {req_q, 2'b00, sr_i, irq_en_q};
        default:  rdata_o = tim_rd;
      endcase
    end
  end

  assign irq_o     = sr_i && irq_en_q;
  assign tx_data_o = tx_q;
  assign setup_o   = setup_q;
  assign strobe_o  = strobe_q;
endmodule

// File: rtl/ibus_seq.sv
module ibus_seq
  import ibus_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [3:0]       code_i,
  input  logic             hl_i,
  input  logic             ack_i,
  input  logic [7:0]       tx_data_i,
  input  logic [CNT_W-1:0] setup_i,
  input  logic [CNT_W-1:0] strobe_i,
  input  logic [7:0]       bus_d_i,
  output logic             busy_o,
  output logic             cap_valid_o,
  output logic             cap_ack_o,
  output logic [7:0]       cap_data_o,
  output logic [3:0]       cmd_o,
  output logic             rdy_o,
  output logic             hl_o,
  output logic             ack_o,
  output logic             oe_o,
  output logic             dir_o,
  output logic [7:0]       bus_d_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       code_q;
  logic             hl_q, ack_q, dir_q;
  logic             dir_need, active;

  assign dir_need = !(ack_i || code_inbound(code_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      code_q  <= '0;
      hl_q    <= 1'b0;
      ack_q   <= 1'b0;
      dir_q   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          code_q <= code_i;
          hl_q   <= hl_i;
          ack_q  <= ack_i;
          cnt_q  <= setup_i;
          // flip only with transceiver off; TURN adds the dead cycle
          if (dir_need != dir_q) begin
            dir_q   <= dir_need;
            state_q <= ST_TURN;
          end else begin
            state_q <= ST_SETUP;
          end
        end
        ST_TURN: state_q <= ST_SETUP;
        ST_SETUP: begin
          if (cnt_q == '0) begin
            cnt_q   <= strobe_i;
            state_q <= ST_STROBE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt_q == '0) state_q <= ST_HOLD;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active      = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
  assign busy_o      = (state_q != ST_IDLE);
  assign oe_o        = active;
  assign dir_o       = dir_q;
  assign cmd_o       = active ? code_q : '0;
  assign hl_o        = active && hl_q;
  assign rdy_o       = (state_q == ST_STROBE) && !ack_q;
  assign ack_o       = (state_q == ST_STROBE) && ack_q;
  assign bus_d_o     = (active && dir_q) ? tx_data_i : '0;
  assign cap_valid_o = (state_q == ST_HOLD) && !dir_q;
  assign cap_ack_o   = ack_q;
  assign cap_data_o  = bus_d_i;
endmodule

// File: rtl/ibus_host_seq.sv
module ibus_host_seq
  import ibus_pkg::*;
#(
  parameter int AW = 10,
  parameter logic [AW-3:0] BASE_ADDR = 8'hC4,
  parameter int CNT_W = 4,
  parameter logic [CNT_W-1:0] DEF_SETUP = 1,
  parameter logic [CNT_W-1:0] DEF_STROBE = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          aen_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic          sr_i,
  output logic          irq_o,
  output logic [3:0]    cmd_o,
  output logic          rdy_o,
  output logic          hl_o,
  output logic          ack_o,
  output logic          bus_oe_o,
  output logic          bus_dir_o,
  output logic [7:0]    bus_d_o,
  input  logic [7:0]    bus_d_i
);
  logic             busy, start, start_hl, start_ack, cap_valid, cap_ack;
  logic [3:0]       start_code;
  logic [7:0]       tx_data, cap_data;
  logic [CNT_W-1:0] setup_cnt, strobe_cnt;

  ibus_host_regs #(
    .AW(AW), .BASE_ADDR(BASE_ADDR), .CNT_W(CNT_W),
    .DEF_SETUP(DEF_SETUP), .DEF_STROBE(DEF_STROBE)
  ) i_regs (
    .clk_i, .rst_ni, .addr_i, .aen_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .sr_i, .irq_o,
    .busy_i(busy), .cap_valid_i(cap_valid), .cap_ack_i(cap_ack), .cap_data_i(cap_data),
    .start_o(start), .start_code_o(start_code), .start_hl_o(start_hl),
    .start_ack_o(start_ack), .tx_data_o(tx_data),
    .setup_o(setup_cnt), .strobe_o(strobe_cnt)
  );

  ibus_seq #(.CNT_W(CNT_W)) i_seq (
    .clk_i, .rst_ni,
    .start_i(start), .code_i(start_code), .hl_i(start_hl), .ack_i(start_ack),
    .tx_data_i(tx_data), .setup_i(setup_cnt), .strobe_i(strobe_cnt),
    .bus_d_i, .busy_o(busy), .cap_valid_o(cap_valid), .cap_ack_o(cap_ack),
    .cap_data_o(cap_data), .cmd_o, .rdy_o, .hl_o, .ack_o,
    .oe_o(bus_oe_o), .dir_o(bus_dir_o), .bus_d_o
  );
endmodule

// File: rtl/ibus_host_seq_chk.sv
module ibus_host_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sr_i,
  input logic       irq_o,
  input logic [3:0] cmd_o,
  input logic       rdy_o,
  input logic       ack_o,
  input logic       bus_oe_o,
  input logic       bus_dir_o,
  input logic [7:0] bus_d_o
);
  assert_strobe_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o || ack_o) |-> bus_oe_o);

  assert_dir_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bus_dir_o) |-> (!bus_oe_o && !$past(bus_oe_o)));

  assert_dead_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> $stable(bus_dir_o));

  assert_setup_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> ($past(bus_oe_o) && $stable(cmd_o) && $stable(bus_d_o)));

  assert_read_inbound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && (cmd_o == 4'd2 || cmd_o == 4'd3 || cmd_o == 4'd4)) |-> !bus_dir_o);

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sr_i);

  assert_ack_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (!rdy_o && !bus_dir_o && bus_oe_o));
endmodule

bind ibus_host_seq ibus_host_seq_chk i_chk (
  .clk_i, .rst_ni, .sr_i, .irq_o, .cmd_o, .rdy_o, .ack_o, .bus_oe_o, .bus_dir_o, .bus_d_o
);

// File: tb/test_ibus_host_seq.sv
`timescale 1ns/1ps
module test_ibus_host_seq;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [9:0] addr_i = '0;
  logic       aen_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, sr_i = 1'b0;
  logic [7:0] wdata_i = '0, bus_d_i = '0;
  logic [7:0] rdata_o, bus_d_o;
  logic       irq_o, rdy_o, hl_o, ack_o, bus_oe_o, bus_dir_o;
  logic [3:0] cmd_o;

  localparam logic [9:0] BASE = 10'h310;

  int checks = 0, fails = 0, cycles = 0;
  int m_turn, m_setup, m_strobe;
  logic [3:0] m_cmd;
  logic [7:0] m_data;
  logic m_hl, m_dir, m_ack, m_rdy;

  always #2.5 clk_i = ~clk_i;

  ibus_host_seq i_ibus_host_seq (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [9:0] a, input logic [7:0] d, input logic aen = 1'b0);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; aen_i = aen; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; aen_i = 1'b0;
  endtask

  task automatic host_rd(input logic [9:0] a, output logic [7:0] d, input logic aen = 1'b0);
    addr_i = a; aen_i = aen; rd_i = 1'b1;
    #0.5 d = rdata_o;
    rd_i = 1'b0; aen_i = 1'b0;
  endtask

  // start a transaction and measure its phases; bus_d_i = decoy until hold
  task automatic run_txn(input logic [3:0] code, input logic hl, input logic ack,
                         input logic [7:0] decoy, input logic [7:0] hold_byte);
    int phase;
    bus_d_i = decoy;
    host_wr(BASE + 1, {2'b00, ack, hl, code});
    m_turn = 0; m_setup = 0; m_strobe = 0; m_cmd = '0; m_data = '0;
    m_hl = 0; m_dir = 0; m_ack = 0; m_rdy = 0; phase = 0;
    for (int i = 0; i < 100; i++) begin
      if (!bus_oe_o) begin
        if (phase == 0) m_turn++;
        else break;
      end else if (rdy_o || ack_o) begin
        phase = 2; m_strobe++;
        m_cmd = cmd_o; m_data = bus_d_o; m_hl = hl_o; m_dir = bus_dir_o;
        m_ack = m_ack | ack_o; m_rdy = m_rdy | rdy_o;
      end else if (phase <= 1) begin
        phase = 1; m_setup++;
      end else begin
        phase = 3; bus_d_i = hold_byte;
      end
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R2 oe after reset", bus_oe_o, 0);
    check("R3 dir after reset", bus_dir_o, 1);
    check("R4 rdy after reset", rdy_o, 0);
    host_rd(BASE + 3, d); check("R5 timing reset", d, 8'h11);
    host_rd(BASE + 1, d); check("R8 busy after reset", d, 0);
  endtask

  task automatic t_decode;
    logic [7:0] d;
    host_wr(BASE + 3, 8'h22, 1'b1);
    host_rd(BASE + 3, d); check("R1 aen blocks write", d, 8'h11);
    host_wr(10'h314 + 3, 8'h33);
    host_rd(BASE + 3, d); check("R1 wrong base ignored", d, 8'h11);
    host_rd(BASE + 3, d, 1'b1); check("R1 aen blocks read", d, 0);
  endtask

  task automatic t_write_seq;
    logic [7:0] d;
    host_wr(BASE + 0, 8'h07);
    run_txn(4'd15, 1'b0, 1'b0, 8'h00, 8'h00);
    check("R11 select code", m_cmd, 15); check("R11 select addr", m_data, 8'h07);
    check("R3 no turn when outbound", m_turn, 0);
    check("R5 default setup", m_setup, 2); check("R5 default strobe", m_strobe, 2);
    host_rd(BASE + 1, d); check("R2 idle after txn / R8 not busy", {d[0], bus_oe_o}, 0);
    host_wr(BASE + 0, 8'h03);
    run_txn(4'd5, 1'b0, 1'b0, 8'h00, 8'h00);
    check("R11 load code", m_cmd, 5); check("R11 load reg addr", m_data, 8'h03);
    host_wr(BASE + 0, 8'h5A);
    run_txn(4'd1, 1'b0, 1'b0, 8'h00, 8'h00);
    check("R11 write code", m_cmd, 1); check("R11 write byte", m_data, 8'h5A);
    check("R12 hl low", m_hl, 0); check("R11 outbound dir", m_dir, 1);
    run_txn(4'd1, 1'b1, 1'b0, 8'h00, 8'h00);
    check("R12 hl high", m_hl, 1);
  endtask

  task automatic t_read;
    logic [7:0] d;
    host_wr(BASE + 3, 8'h00);
    run_txn(4'd2, 1'b0, 1'b0, 8'hC3, 8'h96);
    check("R3 turn cycle to inbound", m_turn, 1);
    check("R6 read inbound", m_dir, 0);
    check("R5 min setup", m_setup, 1); check("R5 min strobe", m_strobe, 1);
    host_rd(BASE + 0, d); check("R7 hold-cycle sample", d, 8'h96);
    run_txn(4'd4, 1'b0, 1'b0, 8'h11, 8'h6C);
    check("R3 no turn staying inbound", m_turn, 0);
    host_rd(BASE + 0, d); check("R7 second read", d, 8'h6C);
    host_wr(BASE + 3, 8'h35);
    host_wr(BASE + 0, 8'hE1);
    run_txn(4'd1, 1'b0, 1'b0, 8'h00, 8'h00);
    check("R3 turn back outbound", m_turn, 1); check("R11 dir out", m_dir, 1);
    check("R5 long setup", m_setup, 6); check("R5 long strobe", m_strobe, 4);
    host_rd(BASE + 3, d); check("R5 readback", d, 8'h35);
  endtask

  task automatic t_busy;
    logic [7:0] d;
    host_wr(BASE + 1, 8'h01);
    host_rd(BASE + 1, d); check("R8 busy set", d, 1);
    host_wr(BASE + 3, 8'h77);
    host_wr(BASE + 0, 8'hFF);
    repeat (20) @(negedge clk_i);
    host_rd(BASE + 1, d); check("R8 busy cleared", d, 0);
    host_rd(BASE + 3, d); check("R8 timing write ignored", d, 8'h35);
    run_txn(4'd1, 1'b0, 1'b0, 8'h00, 8'h00);
    check("R8 data write ignored", m_data, 8'hE1);
  endtask

  task automatic t_ack;
    logic [7:0] d;
    host_wr(BASE + 3, 8'h11);
    run_txn(4'd0, 1'b0, 1'b1, 8'h00, 8'hAB);
    check("R10 ack strobe", m_ack, 1); check("R10 no rdy", m_rdy, 0);
    check("R10 inbound", m_dir, 0);
    host_rd(BASE + 2, d); check("R10 requester addr", d[7:4], 4'hB);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    sr_i = 1'b1; #1; check("R9 masked", irq_o, 0);
    host_wr(BASE + 2, 8'h01); #1; check("R9 enabled", irq_o, 1);
    host_rd(BASE + 2, d); check("R9 enable readback", d[0], 1);
    sr_i = 1'b0; #1; check("R9 no request", irq_o, 0);
    host_wr(BASE + 2, 8'h00); sr_i = 1'b1; #1; check("R9 disabled again", irq_o, 0);
    sr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset; t_decode; t_write_seq; t_read; t_busy; t_ack; t_irq;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 50000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end
endmodule